// File: doc/BRIEF.md
# Flash Read-While-Write Access Controller

This block is the access-control front end of a partitioned flash array. It derives the controller's operating mode from four control-register bits: program, erase, program-suspend and erase-suspend. Using that mode, it decides whether an incoming read is served or refused. It latches the target of an interlock write. It also decides which single block, if any, may be programmed or erased. The array is a plain behavioural memory. A program operation clears bits in the targeted word. An erase operation sets every word of the targeted block to all ones. Each latched interlock applies its operation exactly once.

The array is split into partitions of two or more main blocks each. The first and last block index of each partition are parameters. A shadow block lies outside the main map and forms a partition of its own. A read is refused when it hits the partition that holds the block being written, and only while that write is running. A refused read returns an error response and sets a sticky error flag. Reads to any other partition, to a suspended write's partition, or to block slots that do not exist are served without error.

Reads enter on a valid/ready request channel and leave on a valid/ready response channel that holds one entry. The request side is ready whenever the response register is empty or is being drained in the same cycle. A response stays stable until the consumer takes it. Control, lock, enable and status pins are plain levels.

Top module: `flash_rww_ctrl`

## Requirements
- R1: After reset no response is pending, the error flag and the interlock indication are low, no operation enable is asserted, and every array word reads as all ones.
- R2: A read accepted while no write is running returns, one cycle later, the stored word addressed by shadow bit (address MSB), block index (next BLK_W bits) and word offset (low WORD_W bits), with the error bit low.
- R3: A read accepted while a write is running, whose block lies in the same partition as the latched target, returns the error bit high with data zero and sets the error flag. A write is running when program is set and program-suspend is clear, or when erase is set, erase-suspend is clear and program is clear.
- R4: During a running write, reads to other partitions and to the shadow block (if the target is a main block) are served without error.
- R5: With program and program-suspend both set, or with erase and erase-suspend set and program clear, reads to every partition are served without error and no operation enable is asserted.
- R6: The error flag stays set through later error-free reads. It clears only in a cycle where the clear input is high and no conflicting read is accepted; a conflicting read in the same cycle keeps it set.
- R7: Reads to block indices at or above NUM_BLOCKS return no error, even while a write is running.
- R8: An interlock write is latched only while both program and erase are clear; it is ignored otherwise. The latch clears in the cycle after program and erase both drop from a state where either was set.
- R9: Operation enable bit i (bit 2**BLK_W is the shadow block) is high only when an interlock is latched for block i, a write is running, the block's software lock bit is clear and both hardware enables are high.
- R10: An interlock write to a nonexistent block is latched, but that block never receives an operation enable and the array is not changed.
- R11: On the first enabled cycle of a running program, the latched word becomes the old word ANDed with the latched data. On the first enabled cycle of a running erase, every word of the target block becomes all ones. Neither operation repeats until a new interlock is latched.
- R12: A response is held with unchanged data and error bit while the consumer's ready input is low. Request ready equals "no response pending, or the consumer is ready".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_pgm | input | 1 | Program operation bit |
| cfg_ers | input | 1 | Erase operation bit |
| cfg_psus | input | 1 | Program-suspend bit |
| cfg_esus | input | 1 | Erase-suspend bit |
| hw_en_a | input | 1 | First hardware write enable |
| hw_en_b | input | 1 | Second hardware write enable |
| sw_lock | input | 2**BLK_W+1 | Per-block software lock; top bit is the shadow block |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request ready |
| rd_addr | input | 1+BLK_W+WORD_W | Read address {shadow, block, word} |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | DATA_W | Read data (zero on error) |
| rsp_err | output | 1 | Read refused due to partition conflict |
| il_wr | input | 1 | Interlock write strobe |
| il_addr | input | 1+BLK_W+WORD_W | Interlock address {shadow, block, word} |
| il_data | input | DATA_W | Interlock write data |
| rwe_clr | input | 1 | Write-one-to-clear for the error flag |
| rwe_flag | output | 1 | Sticky read-while-write error flag |
| il_latched | output | 1 | Interlock is held |
| op_en | output | 2**BLK_W+1 | Per-block operation enable |

## Verification
The assertions assume the suspend bits and the operation bits are plain levels that may change in any cycle. They also assume the consumer's ready may drop at any time, and that an interlock strobe may arrive in any mode. They do not assume that any combination of control bits is excluded, because the mode decode defines a result for every combination. The directed stimulus walks through program, erase, both suspends, locking, nonexistent targets, the shadow block and back-pressure. It changes inputs only on the falling edge. A random phase then drives every input freely, and a behavioural reference model mirrors the memory, the latch and the response register.

// File: rtl/flash_rww_pkg.sv
package flash_rww_pkg;
  typedef enum logic [2:0] {
    MD_IDLE  = 3'd0,
    MD_PROG  = 3'd1,
    MD_ERASE = 3'd2,
    MD_PSUSP = 3'd3,
    MD_ESUSP = 3'd4
  } mode_e;
endpackage

// File: rtl/flash_rww_mode.sv
module flash_rww_mode
  import flash_rww_pkg::*;
(
  input  logic pgm,
  input  logic ers,
  input  logic psus,
  input  logic esus,
  output logic prog_run,
  output logic ers_run,
  output logic busy
);
  mode_e mode;

  always_comb begin
    if (pgm && !psus)              mode = MD_PROG;
    else if (ers && !esus && !pgm) mode = MD_ERASE;
    else if (pgm)                  mode = MD_PSUSP;
    else if (ers)                  mode = MD_ESUSP;
    else                           mode = MD_IDLE;
  end

  assign prog_run = (mode == MD_PROG);
  assign ers_run  = (mode == MD_ERASE);
  assign busy     = prog_run | ers_run;
endmodule

// File: rtl/flash_rww_part.sv
module flash_rww_part #(
  parameter int BLK_W    = 3,
  parameter int NUM_PART = 3,
  parameter int PID_W    = 3,
  parameter logic [NUM_PART*BLK_W-1:0] PART_LO = '0,
  parameter logic [NUM_PART*BLK_W-1:0] PART_HI = '0
) (
  input  logic             shadow,
  input  logic [BLK_W-1:0] blk,
  output logic [PID_W-1:0] pid
);
  logic [NUM_PART-1:0] hit;

  for (genvar p = 0; p < NUM_PART; p++) begin : g_range
    assign hit[p] = (blk >= PART_LO[p*BLK_W +: BLK_W]) &&
                    (blk <= PART_HI[p*BLK_W +: BLK_W]);
  end

  always_comb begin
    pid = PID_W'(NUM_PART + 1);
    for (int p = NUM_PART - 1; p >= 0; p--) begin
      if (hit[p]) pid = PID_W'(p);
    end
    if (shadow) pid = PID_W'(NUM_PART);
  end
endmodule

// File: rtl/flash_rww_array.sv
module flash_rww_array #(
  parameter int DATA_W = 32,
  parameter int WORD_W = 4,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [WORD_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data,
  input  logic              prog_en,
  input  logic              erase_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int WORDS = 2 ** WORD_W;
  localparam int DEPTH = 2 ** (SLOT_W + WORD_W);

  logic [DATA_W-1:0] mem [DEPTH];

  assign rd_data = mem[{rd_slot, rd_word}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (erase_en) begin
      for (int w = 0; w < WORDS; w++) mem[{wr_slot, WORD_W'(w)}] <= '1;
    end else if (prog_en) begin
      mem[{wr_slot, wr_word}] <= mem[{wr_slot, wr_word}] & wr_data;
    end
  end
endmodule

// File: rtl/flash_rww_ctrl.sv
module flash_rww_ctrl #(
  parameter int DATA_W     = 32,
  parameter int WORD_W     = 4,
  parameter int BLK_W      = 3,
  parameter int NUM_BLOCKS = 6,
  parameter int NUM_PART   = 3,
  parameter logic [NUM_PART*BLK_W-1:0] PART_LO = {3'd4, 3'd2, 3'd0},
  parameter logic [NUM_PART*BLK_W-1:0] PART_HI = {3'd5, 3'd3, 3'd1},
  localparam int NSLOT  = 2 ** BLK_W,
  localparam int ADDR_W = 1 + BLK_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_pgm,
  input  logic              cfg_ers,
  input  logic              cfg_psus,
  input  logic              cfg_esus,
  input  logic              hw_en_a,
  input  logic              hw_en_b,
  input  logic [NSLOT:0]    sw_lock,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  input  logic              il_wr,
  input  logic [ADDR_W-1:0] il_addr,
  input  logic [DATA_W-1:0] il_data,
  input  logic              rwe_clr,
  output logic              rwe_flag,
  output logic              il_latched,
  output logic [NSLOT:0]    op_en
);
  localparam int SLOT_W   = BLK_W + 1;
  localparam int PID_W    = $clog2(NUM_PART + 2);
  localparam int PID_NONE = NUM_PART + 1;

  logic prog_run, ers_run, busy, any_op, op_q, applied;
  logic tgt_sh;
  logic [BLK_W-1:0]  tgt_blk;
  logic [WORD_W-1:0] tgt_word;
  logic [DATA_W-1:0] tgt_data, arr_rd;
  logic [PID_W-1:0]  rd_pid, tgt_pid;
  logic [SLOT_W-1:0] rd_slot, tgt_slot;
  logic rd_sh, tgt_exist, gate, conflict, acc, prog_go, erase_go;
  logic [BLK_W-1:0]  rd_blk;
  logic [WORD_W-1:0] rd_word;

  flash_rww_mode u_mode (
    .pgm(cfg_pgm), .ers(cfg_ers), .psus(cfg_psus), .esus(cfg_esus),
    .prog_run(prog_run), .ers_run(ers_run), .busy(busy)
  );

  assign rd_sh    = rd_addr[ADDR_W-1];
  assign rd_blk   = rd_addr[WORD_W +: BLK_W];
  assign rd_word  = rd_addr[WORD_W-1:0];
  assign rd_slot  = rd_sh  ? SLOT_W'(NSLOT) : {1'b0, rd_blk};
  assign tgt_slot = tgt_sh ? SLOT_W'(NSLOT) : {1'b0, tgt_blk};

  flash_rww_part #(
    .BLK_W(BLK_W), .NUM_PART(NUM_PART), .PID_W(PID_W),
    .PART_LO(PART_LO), .PART_HI(PART_HI)
  ) u_rd_part (.shadow(rd_sh), .blk(rd_blk), .pid(rd_pid));

  flash_rww_part #(
    .BLK_W(BLK_W), .NUM_PART(NUM_PART), .PID_W(PID_W),
    .PART_LO(PART_LO), .PART_HI(PART_HI)
  ) u_tgt_part (.shadow(tgt_sh), .blk(tgt_blk), .pid(tgt_pid));

  // Read path and conflict decision
  assign conflict = busy && il_latched && (rd_pid == tgt_pid) &&
                    (rd_pid != PID_W'(PID_NONE));
  assign rd_ready = !rsp_valid || rsp_ready;
  assign acc      = rd_valid && rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_err   <= conflict;
      rsp_data  <= conflict ? '0 : arr_rd;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rwe_flag <= 1'b0;
    else if (acc && conflict)  rwe_flag <= 1'b1;
    else if (rwe_clr)          rwe_flag <= 1'b0;
  end

  // Interlock latch
  assign any_op = cfg_pgm || cfg_ers;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      il_latched <= 1'b0;
      op_q       <= 1'b0;
      applied    <= 1'b0;
      tgt_sh     <= 1'b0;
      tgt_blk    <= '0;
      tgt_word   <= '0;
      tgt_data   <= '0;
    end else begin
      op_q <= any_op;
      if (il_wr && !any_op) begin
        il_latched <= 1'b1;
        applied    <= 1'b0;
        tgt_sh     <= il_addr[ADDR_W-1];
        tgt_blk    <= il_addr[WORD_W +: BLK_W];
        tgt_word   <= il_addr[WORD_W-1:0];
        tgt_data   <= il_data;
      end else begin
        if (op_q && !any_op) il_latched <= 1'b0;
        if (prog_go || erase_go) applied <= 1'b1;
      end
    end
  end

  // Operation enables
  assign tgt_exist = tgt_sh || (32'(tgt_blk) < NUM_BLOCKS);
  assign gate      = il_latched && busy && hw_en_a && hw_en_b && tgt_exist;

  for (genvar i = 0; i <= NSLOT; i++) begin : g_en
    assign op_en[i] = gate && (tgt_slot == SLOT_W'(i)) && !sw_lock[i];
  end

  assign prog_go  = (|op_en) && prog_run && !applied;
  assign erase_go = (|op_en) && ers_run  && !applied;

  flash_rww_array #(
    .DATA_W(DATA_W), .WORD_W(WORD_W), .SLOT_W(SLOT_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .rd_slot(rd_slot), .rd_word(rd_word), .rd_data(arr_rd),
    .prog_en(prog_go), .erase_en(erase_go),
    .wr_slot(tgt_slot), .wr_word(tgt_word), .wr_data(tgt_data)
  );

  // Assertions
  p_err_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && conflict |=> rsp_valid && rsp_err && rwe_flag);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rwe_flag && !rwe_clr |=> rwe_flag);

  p_no_latch_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_op && !il_latched |=> !il_latched);

  p_en_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|op_en) |-> hw_en_a && hw_en_b && il_latched && busy);

  p_en_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(op_en));

  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err));

  p_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !rd_ready);
endmodule

// File: tb/flash_rww_ctrl_tb.sv
module flash_rww_ctrl_tb;
  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic d_pgm, d_ers, d_psus, d_esus, d_hwa, d_hwb, d_rdv, d_rspr, d_ilwr, d_clr;
  logic [8:0] d_lock;
  logic [7:0] d_rda, d_ila;
  logic [31:0] d_ild;

  logic s_pgm = 0, s_ers = 0, s_psus = 0, s_esus = 0, s_hwa = 1, s_hwb = 1;
  logic s_rdv = 0, s_rspr = 1, s_ilwr = 0, s_clr = 0;
  logic [8:0] s_lock = '0;
  logic [7:0] s_rda = '0, s_ila = '0;
  logic [31:0] s_ild = '0;

  logic rd_ready, rsp_valid, rsp_err, rwe_flag, il_latched;
  logic [31:0] rsp_data;
  logic [8:0] op_en;

  flash_rww_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_pgm(d_pgm), .cfg_ers(d_ers), .cfg_psus(d_psus), .cfg_esus(d_esus),
    .hw_en_a(d_hwa), .hw_en_b(d_hwb), .sw_lock(d_lock),
    .rd_valid(d_rdv), .rd_ready(rd_ready), .rd_addr(d_rda),
    .rsp_valid(rsp_valid), .rsp_ready(d_rspr), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .il_wr(d_ilwr), .il_addr(d_ila), .il_data(d_ild),
    .rwe_clr(d_clr), .rwe_flag(rwe_flag), .il_latched(il_latched), .op_en(op_en)
  );

  // Reference model state
  logic [31:0] mm [0:255];
  bit m_v, m_err, m_known, m_flag, m_lat, m_app, m_opq, m_tsh;
  int m_tblk, m_tword;
  logic [31:0] m_data, m_tdata;
  int vectors = 0, fails = 0;
  string cur_req = "R1";

  function automatic int mpid(bit sh, int blk);
    if (sh) return 100;
    if (blk < 6) return blk / 2;
    return -1;
  endfunction

  function automatic bit m_busy();
    return (d_pgm && !d_psus) || (d_ers && !d_esus && !d_pgm);
  endfunction

  function automatic logic [8:0] m_open();
    logic [8:0] e = '0;
    int ts = m_tsh ? 8 : m_tblk;
    bit ex = m_tsh || m_tblk < 6;
    for (int i = 0; i < 9; i++)
      e[i] = m_lat && m_busy() && d_hwa && d_hwb && ex && ts == i && !d_lock[i];
    return e;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 256; i++) mm[i] = '1;
    m_v = 0; m_err = 0; m_known = 0; m_flag = 0; m_lat = 0; m_app = 0; m_opq = 0;
    m_tsh = 0; m_tblk = 0; m_tword = 0; m_data = '0; m_tdata = '0;
  endtask

  task automatic model_step();
    bit any = d_pgm || d_ers;
    bit rdy = !m_v || d_rspr;
    bit acc = d_rdv && rdy;
    bit rsh = d_rda[7];
    int rblk = int'(d_rda[6:4]);
    int rword = int'(d_rda[3:0]);
    bit conf = m_busy() && m_lat && mpid(rsh, rblk) == mpid(m_tsh, m_tblk) &&
               mpid(rsh, rblk) != -1;
    logic [8:0] e = m_open();
    int ts = m_tsh ? 8 : m_tblk;
    if (acc) begin
      m_v = 1; m_err = conf;
      m_data = conf ? 32'h0 : mm[(rsh ? 8 : rblk) * 16 + rword];
      m_known = conf || rsh || rblk < 6;
    end else if (d_rspr) m_v = 0;
    if (acc && conf) m_flag = 1;
    else if (d_clr) m_flag = 0;
    if (e != 0 && !m_app) begin
      if (d_pgm && !d_psus) mm[ts * 16 + m_tword] = mm[ts * 16 + m_tword] & m_tdata;
      else for (int w = 0; w < 16; w++) mm[ts * 16 + w] = '1;
    end
    if (d_ilwr && !any) begin
      m_lat = 1; m_app = 0; m_tsh = d_ila[7];
      m_tblk = int'(d_ila[6:4]); m_tword = int'(d_ila[3:0]); m_tdata = d_ild;
    end else begin
      if (m_opq && !any) m_lat = 0;
      if (e != 0) m_app = 1;
    end
    m_opq = any;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s, phase %s): actual %h expected %h", req, what, cur_req, act, exp);
    end
  endtask

  task automatic compare();
    vectors++;
    chk("R12", "rd_ready", 32'(rd_ready), 32'(!m_v || d_rspr));
    chk("R12", "rsp_valid", 32'(rsp_valid), 32'(m_v));
    if (m_v) begin
      chk("R3", "rsp_err", 32'(rsp_err), 32'(m_err));
      if (m_known) chk("R2", "rsp_data", rsp_data, m_data);
    end
    chk("R6", "rwe_flag", 32'(rwe_flag), 32'(m_flag));
    chk("R8", "il_latched", 32'(il_latched), 32'(m_lat));
    chk("R9", "op_en", 32'(op_en), 32'(m_open()));
  endtask

  task automatic tick();
    @(negedge clk);
    d_pgm = s_pgm; d_ers = s_ers; d_psus = s_psus; d_esus = s_esus;
    d_hwa = s_hwa; d_hwb = s_hwb; d_lock = s_lock; d_rdv = s_rdv; d_rspr = s_rspr;
    d_ilwr = s_ilwr; d_clr = s_clr; d_rda = s_rda; d_ila = s_ila; d_ild = s_ild;
    #1 compare();
    @(posedge clk);
    #1 model_step();
  endtask

  task automatic rd(logic [7:0] a);
    s_rdv = 1; s_rda = a; tick(); s_rdv = 0; tick();
  endtask

  task automatic ilw(logic [7:0] a, logic [31:0] d);
    s_ilwr = 1; s_ila = a; s_ild = d; tick(); s_ilwr = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    d_pgm = 0; d_ers = 0; d_psus = 0; d_esus = 0; d_hwa = 1; d_hwb = 1; d_lock = '0;
    d_rdv = 0; d_rspr = 1; d_ilwr = 0; d_clr = 0; d_rda = '0; d_ila = '0; d_ild = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    cur_req = "R1"; tick(); rd(8'h00); rd(8'h8F);          // reset state, erased words
    cur_req = "R8"; ilw(8'h13, 32'h1234_5678); tick();      // latch block 1 word 3
    cur_req = "R9"; s_pgm = 1; tick(); tick();              // enable bit 1, program applied
    cur_req = "R3"; rd(8'h03); rd(8'h13);                   // same partition refused
    cur_req = "R4"; rd(8'h23); rd(8'h80); rd(8'h53);        // other partitions, shadow
    cur_req = "R6"; rd(8'h40); s_clr = 1; s_rdv = 1; s_rda = 8'h00; tick();
    s_clr = 0; s_rdv = 0; tick();                           // set wins over clear
    cur_req = "R8"; ilw(8'h20, 32'h0); tick();              // ignored while busy
    cur_req = "R5"; s_psus = 1; rd(8'h13); rd(8'h03);       // program suspended
    s_psus = 0; s_pgm = 0; tick(); tick();                  // latch clears
    cur_req = "R11"; rd(8'h13); rd(8'h12);
    cur_req = "R6"; s_clr = 1; tick(); s_clr = 0; tick(); rd(8'h00);
    cur_req = "R12"; s_rspr = 0; s_rdv = 1; s_rda = 8'h13; tick(); s_rda = 8'h20;
    repeat (3) tick(); s_rspr = 1; tick(); s_rdv = 0; tick();
    cur_req = "R11"; ilw(8'h10, 32'h0); s_ers = 1; tick(); tick();
    cur_req = "R3"; rd(8'h05); cur_req = "R5"; s_esus = 1; rd(8'h05); rd(8'h13);
    s_esus = 0; s_ers = 0; tick(); tick();
    cur_req = "R11"; rd(8'h13);
    cur_req = "R9"; s_lock[4] = 1; ilw(8'h41, 32'h0F0F_0F0F); s_pgm = 1; tick(); tick();
    s_pgm = 0; tick(); tick(); s_lock[4] = 0; rd(8'h41);
    s_hwb = 0; ilw(8'h41, 32'h0); s_pgm = 1; tick(); tick(); s_pgm = 0; tick(); tick();
    s_hwb = 1; rd(8'h41);
    cur_req = "R10"; ilw(8'h65, 32'h0); s_pgm = 1; tick(); tick();
    cur_req = "R7"; rd(8'h60); rd(8'h75); s_pgm = 0; tick(); tick();
    cur_req = "R4"; ilw(8'h82, 32'h0000_00A5); s_pgm = 1; tick(); tick();
    rd(8'h82); rd(8'h02); s_pgm = 0; tick(); tick(); rd(8'h82);

    cur_req = "R2";
    for (int n = 0; n < 3000; n++) begin
      s_pgm = ($urandom % 5) == 0; s_ers = ($urandom % 6) == 0;
      s_psus = ($urandom % 3) == 0; s_esus = ($urandom % 3) == 0;
      s_hwa = ($urandom % 8) != 0; s_hwb = ($urandom % 8) != 0;
      s_lock = 9'($urandom) & 9'($urandom); s_rdv = $urandom % 2;
      s_rspr = ($urandom % 4) != 0; s_ilwr = ($urandom % 4) == 0;
      s_clr = ($urandom % 10) == 0; s_rda = 8'($urandom); s_ila = 8'($urandom);
      s_ild = $urandom;
      tick();
    end
    finish_run();
  end
endmodule